// File: doc/BRIEF.md
# Free-Running Counter with Overflow Flag

This block is a 16-bit up-counter that never stops or reloads. On every clock where its chosen count source fires, it adds one. Eight sources are available. Six are strobes from a shared prescaler, one per tap. The other two are the rising or falling edge of an external pin, which is first passed through a two-flop synchronizer. When the count rolls over from all ones to zero, a sticky overflow flag is set. If the interrupt level field is non-zero, the flag raises an interrupt request.

A single 16-bit control/status word is read and written through plain strobes. It holds:
- the overflow flag,
- the interrupt level,
- an arbitration bit passed to the interrupt bus,
- two enables that place the count on time-base bus A and bus B,
- a read-only copy of the synchronized pin,
- the source select.

To clear the flag, software must first read it while it is set and then write a zero to it. Any overflow that arrives in between cancels that clear.

The two time-base buses are one-way broadcasts. Each carries a valid bit and the count. There is no ready input and no back-pressure: a listener samples the data in any cycle where valid is high. While its enable is off, a bus shows zero with valid low.

Top module: `frc_timer`

## Requirements
- R1: After reset, the control/status word reads 0x0000 except for bit 7, which still follows the pin. The counter is zero, both bus valids are low and the interrupt request is low.
- R2: The counter goes up by exactly one for each enable of the selected source. Stepping from 0xFFFF to 0x0000 sets the overflow flag at bit 15 in the same clock.
- R3: The interrupt request is high exactly while the flag is set and the level field (bits 14:12) is non-zero. The level output equals that field while the request is high and is zero otherwise. The arbitration output follows bit 11.
- R4: A write of 0 to bit 15 clears the flag only if an earlier read returned bit 15 as 1. A write with no such read leaves the flag set, and writing 1 to bit 15 never changes the flag.
- R5: If an overflow occurs after the arming read and before the clearing write, that write leaves the flag set.
- R6: Select codes 0 to 5 (bits 2:0) pick prescaler tap strobes tap_en[0] to tap_en[5]. Strobes on any other tap do not move the counter.
- R7: Select code 6 counts falling edges of the pin and code 7 counts rising edges. Each edge gives exactly one count, no matter how long the pin then holds its level.
- R8: Bit 7 reads the synchronized pin level, and writes to bit 7 have no effect.
- R9: Bit 9 enables bus A and bit 8 enables bus B, and both may be on together. While an enable is off, that bus shows valid low and data zero. While it is on, the bus shows valid high and the current count.
- R10: Bits 10 and 6:3 always read as zero. The level, arbitration, drive and select fields read back exactly what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_en | input | 6 | Prescaler tap strobes, one bit per tap |
| pin_in | input | 1 | External count pin (asynchronous) |
| reg_rd | input | 1 | Read strobe for the control/status word |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control/status word |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Priority level of the request |
| irq_arb | output | 1 | Arbitration bit presented with the request |
| tba_valid | output | 1 | Bus A carries the count |
| tba_data | output | 16 | Bus A count value |
| tbb_valid | output | 1 | Bus B carries the count |
| tbb_data | output | 16 | Bus B count value |

## Verification
The hardest case to reach from the ports is an overflow that lands between the arming read and the clearing write. The counter cannot be preloaded, so the only way to get there is to count through the whole 16-bit range.

The stimulus holds one tap strobe high continuously and steps the count to exactly 0xFFFF to check the wrap. It then issues the arming read and runs a second full 65,536-count lap before the write. This shows the write is cancelled, and then the clear succeeds after a fresh read.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int WORD_W  = 16;
  localparam int B_OVF   = 15;
  localparam int B_LVL_LO = 12;
  localparam int B_ARB   = 11;
  localparam int B_DRV_A = 9;
  localparam int B_DRV_B = 8;
  localparam int B_PIN   = 7;

  typedef enum logic [2:0] {
    SRC_TAP1 = 3'd0, SRC_TAP2 = 3'd1, SRC_TAP3 = 3'd2,
    SRC_TAP4 = 3'd3, SRC_TAP5 = 3'd4, SRC_TAP6 = 3'd5,
    SRC_PIN_FALL = 3'd6, SRC_PIN_RISE = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic [2:0] lvl;
    logic       arb;
    logic       drv_a;
    logic       drv_b;
    src_sel_e   sel;
  } ctl_t;
endpackage

// File: rtl/frc_edge_sync.sv
module frc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_sync,
  output logic pin_rise,
  output logic pin_fall
);
  // Synchroniser flops carry no reset so the pin view survives reset.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-1:0], pin_in};
  end

  assign pin_sync = chain[STAGES-1];
  assign pin_rise = chain[STAGES-1] & ~chain[STAGES];
  assign pin_fall = ~chain[STAGES-1] & chain[STAGES];

  // R7: one enable per edge, never two in a row
  p_single_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
  p_single_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall);
endmodule

// File: rtl/frc_src_mux.sv
module frc_src_mux #(
  parameter int NUM_TAPS = 6,
  localparam int SEL_W = $clog2(NUM_TAPS + 2),
  localparam int EXT_W = 2 ** SEL_W
) (
  input  logic [NUM_TAPS-1:0] tap_en,
  input  logic                pin_rise,
  input  logic                pin_fall,
  input  logic [SEL_W-1:0]    sel,
  output logic                cnt_en
);
  logic [EXT_W-1:0] taps_ext;
  assign taps_ext = EXT_W'(tap_en);

  always_comb begin
    if (32'(sel) < NUM_TAPS)
      cnt_en = taps_ext[sel];
    else if (32'(sel) == NUM_TAPS)
      cnt_en = pin_fall;
    else if (32'(sel) == NUM_TAPS + 1)
      cnt_en = pin_rise;
    else
      cnt_en = 1'b0;
  end
endmodule

// File: rtl/frc_count_core.sv
module frc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = cnt_en && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  // R2: single step per enable, hold otherwise
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == $past(cnt) + 1'b1);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));
endmodule

// File: rtl/frc_ovf_flag.sv
module frc_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic rd,
  input  logic wr,
  input  logic wr_flag_bit,
  output logic flag
);
  logic armed;
  logic do_clear;

  assign do_clear = wr && !wr_flag_bit && armed && !wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (wrap)          flag <= 1'b1;
      else if (do_clear) flag <= 1'b0;

      if (wrap)                       armed <= 1'b0;
      else if (rd && flag && !do_clear) armed <= 1'b1;
      else if (wr)                    armed <= 1'b0;
    end
  end

  p_wrap_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  p_clear_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed) && $past(wr) && !$past(wr_flag_bit));
  p_wrap_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !armed);
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_TAPS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tap_en,
  input  logic                pin_in,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_req,
  output logic [2:0]          irq_lvl,
  output logic                irq_arb,
  output logic                tba_valid,
  output logic [CNT_W-1:0]    tba_data,
  output logic                tbb_valid,
  output logic [CNT_W-1:0]    tbb_data
);
  localparam int SEL_W = $clog2(NUM_TAPS + 2);

  ctl_t             ctl;
  logic             pin_sync, pin_rise, pin_fall;
  logic             cnt_en, wrap, flag;
  logic [CNT_W-1:0] cnt;

  frc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .pin_sync(pin_sync), .pin_rise(pin_rise), .pin_fall(pin_fall));

  frc_src_mux #(.NUM_TAPS(NUM_TAPS)) u_mux (
    .tap_en(tap_en), .pin_rise(pin_rise), .pin_fall(pin_fall),
    .sel(SEL_W'(ctl.sel)), .cnt_en(cnt_en));

  frc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt), .wrap(wrap));

  frc_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .rd(reg_rd), .wr(reg_wr),
    .wr_flag_bit(reg_wdata[B_OVF]), .flag(flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (reg_wr) begin
      ctl.lvl   <= reg_wdata[B_LVL_LO +: 3];
      ctl.arb   <= reg_wdata[B_ARB];
      ctl.drv_a <= reg_wdata[B_DRV_A];
      ctl.drv_b <= reg_wdata[B_DRV_B];
      ctl.sel   <= src_sel_e'(reg_wdata[2:0]);
    end
  end

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[B_OVF]       = flag;
    reg_rdata[B_LVL_LO +: 3] = ctl.lvl;
    reg_rdata[B_ARB]       = ctl.arb;
    reg_rdata[B_DRV_A]     = ctl.drv_a;
    reg_rdata[B_DRV_B]     = ctl.drv_b;
    reg_rdata[B_PIN]       = pin_sync;
    reg_rdata[2:0]         = ctl.sel;
  end

  assign irq_req   = flag && (ctl.lvl != 3'd0);
  assign irq_lvl   = irq_req ? ctl.lvl : 3'd0;
  assign irq_arb   = ctl.arb;
  assign tba_valid = ctl.drv_a;
  assign tbb_valid = ctl.drv_b;
  assign tba_data  = ctl.drv_a ? cnt : '0;
  assign tbb_data  = ctl.drv_b ? cnt : '0;

  // R3: a raised request follows an overflow seen with a non-zero level
  p_irq_after_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !reg_wr && (ctl.lvl != 3'd0) |=> irq_req);
  // R10: control fields hold without a write
  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ctl));
endmodule

// File: tb/frc_timer_test.sv
module frc_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  tap_en = '0;
  logic        pin_in = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req, irq_arb, tba_valid, tbb_valid;
  logic [2:0]  irq_lvl;
  logic [15:0] tba_data, tbb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frc_timer uut (
    .clk(clk), .rst_n(rst_n), .tap_en(tap_en), .pin_in(pin_in),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .irq_arb(irq_arb), .tba_valid(tba_valid), .tba_data(tba_data),
    .tbb_valid(tbb_valid), .tbb_data(tbb_data));

  typedef struct packed {
    logic [15:0] wdata;
    logic [15:0] expect_rd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'h7B07},
    '{16'h0000, 16'h0000},
    '{16'h5A5A, 16'h5A02},
    '{16'hA5A5, 16'h2105},
    '{16'h1300, 16'h1300},
    '{16'h0478, 16'h0000},
    '{16'h0887, 16'h0807}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [15:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg();
    reg_rd = 1'b1;
    step(1);
    reg_rd = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 word", reg_rdata, 32'h0);
    chk("R1 irq", irq_req, 1'b0);
    chk("R1 valids", {tba_valid, tbb_valid}, 2'b00);
    chk("R1 bus A data", tba_data, 16'h0);

    // R10 / R4 / R8 register vectors
    for (int i = 0; i < NV; i++) begin
      wr_reg(VECS[i].wdata);
      chk("R10 readback", reg_rdata, VECS[i].expect_rd);
      chk("R9 valids", {tba_valid, tbb_valid}, VECS[i].expect_rd[9:8]);
    end

    // R6 tap select
    wr_reg(16'h0202);
    tap_en = 6'b111011; step(10); tap_en = '0;
    chk("R6 other taps ignored", tba_data, 16'd0);
    tap_en = 6'b000100; step(5); tap_en = '0;
    chk("R6 tap3 counts", tba_data, 16'd5);
    wr_reg(16'h0205);
    tap_en = 6'b100000; step(3); tap_en = '0;
    chk("R6 tap6 counts", tba_data, 16'd8);
    chk("R9 bus B off data", tbb_data, 16'd0);
    chk("R9 bus B off valid", tbb_valid, 1'b0);
    wr_reg(16'h0305);
    chk("R9 both buses", {tba_data, tbb_data}, {16'd8, 16'd8});
    wr_reg(16'h0105);
    chk("R9 bus A off", {tba_valid, tba_data}, {1'b0, 16'd0});

    // R7 rising edges
    wr_reg(16'h0207);
    for (int i = 0; i < 4; i++) begin
      pin_in = 1'b1; step(10);
      if (i == 0) chk("R8 pin reads high", reg_rdata[7], 1'b1);
      pin_in = 1'b0; step(4);
    end
    chk("R7 rising count", tba_data, 16'd12);
    chk("R8 pin reads low", reg_rdata[7], 1'b0);
    // R7 falling edges
    wr_reg(16'h0206);
    for (int i = 0; i < 3; i++) begin
      pin_in = 1'b1; step(4);
      pin_in = 1'b0; step(10);
    end
    chk("R7 falling count", tba_data, 16'd15);
    pin_in = 1'b1; step(4);
    wr_reg(16'h0287);
    chk("R8 write to pin bit ignored", reg_rdata, 16'h0287);
    pin_in = 1'b0; step(4);

    // R2 wrap, tap1, level 1
    wr_reg(16'h1200);
    tap_en = 6'b000001; step(65520); tap_en = '0;
    chk("R2 at max", tba_data, 16'hFFFF);
    chk("R2 no flag yet", reg_rdata[15], 1'b0);
    chk("R3 no irq yet", irq_req, 1'b0);
    tap_en = 6'b000001; step(1); tap_en = '0;
    chk("R2 wrapped", tba_data, 16'h0000);
    chk("R2 flag set", reg_rdata[15], 1'b1);
    chk("R3 irq", {irq_req, irq_lvl}, {1'b1, 3'd1});

    // R4 write without read
    wr_reg(16'h1200);
    chk("R4 unarmed write", reg_rdata[15], 1'b1);
    // R5 read, overflow, write
    rd_reg();
    tap_en = 6'b000001; step(65536); tap_en = '0;
    chk("R5 second wrap", tba_data, 16'h0000);
    wr_reg(16'h1200);
    chk("R5 clear cancelled", reg_rdata[15], 1'b1);

    // R3 level zero masks request
    wr_reg(16'h0A00);
    chk("R3 level zero", {irq_req, irq_lvl, irq_arb}, {1'b0, 3'd0, 1'b1});
    wr_reg(16'h7200);
    chk("R3 level seven", {irq_req, irq_lvl, irq_arb}, {1'b1, 3'd7, 1'b0});

    // R4 read then write one: no effect
    rd_reg();
    wr_reg(16'hF200);
    chk("R4 write one", reg_rdata[15], 1'b1);
    // R4 proper clear
    rd_reg();
    wr_reg(16'h7200);
    chk("R4 cleared", reg_rdata[15], 1'b0);
    chk("R4 irq dropped", irq_req, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule